// File: doc/BRIEF.md
# Bus Cycle Termination Monitor

This block sits beside an asynchronous external bus and decides how each bus cycle ends. An external master asserts address strobe to start a cycle. The block watches the acknowledge inputs, the external bus error input, and flags that describe the cycle. These flags mark an interrupt-acknowledge cycle, contention during interrupt arbitration, or the broadcast cycle that announces low-power stop. Each cycle ends either with a one-clock normal-termination pulse or with a one-clock internal bus-error pulse. A cycle that the master abandons, by dropping address strobe, ends with no pulse at all.

The block merges three error sources into one termination decision. The first is a bus-monitor timeout whose length is programmable. The second is a detector for spurious interrupt acknowledges. The third is the external bus error. All three are masked during the low-power-stop broadcast cycle. A halt request holds the bus between cycles, so the master can step through cycles one at a time. Every input is captured in a register on the rising clock edge before it is used.

The controller has four states. ST_IDLE waits for a cycle. ST_ACTIVE evaluates the cycle and runs the timeout counter. ST_DONE waits for address strobe to negate after a termination. ST_HALT holds the bus while halt is sampled.

The transitions are as follows:
- ST_IDLE goes to ST_HALT on sampled halt. Otherwise it goes to ST_ACTIVE on sampled strobe.
- ST_ACTIVE returns to ST_IDLE when strobe is lost. It goes to ST_DONE on an error, with an error pulse, or on an acknowledge, with an OK pulse.
- ST_DONE leaves when strobe negates. It goes to ST_HALT if halt is sampled and to ST_IDLE otherwise.
- ST_HALT goes to ST_IDLE when halt is released.

Top module: `bus_term_monitor`

## Requirements
- R1: When a cycle ends on an acknowledge, `term_ok_o` pulses for exactly one clock. An acknowledge is either bit of `size_ack_i` at 1, or `vec_ack_i` at 1. Count the rising edge that first samples the strobe as edge 1. With the acknowledge present from that same edge, the pulse is visible after edge 3.
- R2: With `tmo_en_i`=1 and no acknowledge, `int_berr_o` pulses after edge LIMIT+2, counting as in R1. LIMIT is 8, 16, 32 or 64 for `tmo_sel_i` = 0, 1, 2 or 3.
- R3: If address strobe negates before a cycle terminates, the block produces no pulse and clears the timeout count. The next cycle is timed from its own start.
- R4: An interrupt-acknowledge cycle (`intack_cycle_i`=1) with `arb_clash_i`=0 ends with `int_berr_o` after edge 3, even when an acknowledge is present. With `arb_clash_i`=1, such a cycle ends normally on an acknowledge.
- R5: An external bus error (`bus_err_i`=1) ends the cycle with `int_berr_o` after edge 3.
- R6: If an error source and an acknowledge are sampled on the same clock, only `int_berr_o` pulses. This also holds when an acknowledge arrives on the clock that the timeout expires.
- R7: While `stop_bcast_i`=1, the external error, the timeout and the spurious detector produce no pulse. The cycle ends only on an acknowledge, which gives `term_ok_o` two edges after the acknowledge is driven.
- R8: With `tmo_en_i`=0, the timeout never fires and a cycle waits for an acknowledge for as long as it takes. The spurious detector still works.
- R9: A halt that is sampled while idle, or at the end of a cycle, drives `step_hold_o`=1. No new cycle is evaluated until halt is released. After release, a waiting strobe and acknowledge give `term_ok_o` after edge 4, counting from the edge that samples the release.
- R10: `term_ok_o` and `int_berr_o` never pulse together, and neither lasts more than one clock. After a termination, the block evaluates no further cycle until it has sampled address strobe negated.
- R11: While `rst_n`=0, all outputs are 0. After reset the block starts in ST_IDLE, so no pulse can occur before a strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. All inputs are sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strobe_i | input | 1 | Address strobe; a cycle is in progress while it is 1 |
| size_ack_i | input | 2 | Data-size acknowledge; either bit at 1 acknowledges the cycle |
| vec_ack_i | input | 1 | Autovector acknowledge |
| bus_err_i | input | 1 | External bus error |
| halt_req_i | input | 1 | Halt request for single-cycle stepping |
| intack_cycle_i | input | 1 | The current cycle is an interrupt acknowledge |
| arb_clash_i | input | 1 | Contention was seen during interrupt arbitration |
| stop_bcast_i | input | 1 | The current cycle is the low-power-stop broadcast |
| tmo_en_i | input | 1 | Enables the bus-monitor timeout |
| tmo_sel_i | input | 2 | Timeout length select: LIMIT = 8 << value |
| term_ok_o | output | 1 | One-clock normal-termination pulse |
| int_berr_o | output | 1 | One-clock internal bus-error pulse |
| step_hold_o | output | 1 | Bus held between cycles by halt |

## Verification
The assertions relate each pulse to the inputs two edges earlier. They therefore assume that the acknowledge and broadcast inputs are stable from the cycle's first sampled edge until the pulse is seen. They also assume that a cycle's flags do not change while that cycle is in progress.

The stimulus meets these assumptions. It changes inputs only at falling edges and holds each cycle's flags for the whole cycle. The only exceptions are the acknowledge, which is raised late on purpose in the timeout-race and broadcast cases, and the strobe, which is dropped to abort a cycle. Between cycles the bench returns every input to 0 and leaves several idle clocks.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2,
        ST_HALT   = 2'd3
    } bt_state_e;

    // One clock's worth of sampled bus inputs
    typedef struct packed {
        logic       strobe;
        logic [1:0] size_ack;
        logic       vec_ack;
        logic       ext_err;
        logic       halt;
        logic       intack;
        logic       clash;
        logic       stop;
        logic       tmo_en;
    } bt_samp_t;

endpackage

// File: rtl/bt_sampler.sv
module bt_sampler
    import bus_term_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bt_samp_t         samp_d,
    input  logic [SEL_W-1:0] sel_d,
    output bt_samp_t         samp_q,
    output logic [SEL_W-1:0] sel_q
);

    // Single capture stage on the rising edge; nothing downstream sees raw pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            sel_q  <= '0;
        end else begin
            samp_q <= samp_d;
            sel_q  <= sel_d;
        end
    end

endmodule

// File: rtl/bt_timeout.sv
module bt_timeout #(
    parameter int BASE_TMO = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int MAX_LIM = BASE_TMO << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LIM) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;

    always_comb begin
        lim_m1 = (CNT_W'(BASE_TMO) << sel) - CNT_W'(1);
    end

    assign expire = run && (cnt == lim_m1);

    // The count is held at zero outside an evaluated cycle, so losing strobe clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bt_err_decode.sv
module bt_err_decode
    import bus_term_pkg::*;
(
    input  bt_samp_t samp,
    input  logic     expire,
    output logic     err_hit,
    output logic     ack_hit
);

    logic spurious;
    logic timed_out;

    always_comb begin
        spurious  = samp.intack && !samp.clash;
        timed_out = samp.tmo_en && expire;
        // Broadcast cycle masks every error source
        err_hit   = !samp.stop && (samp.ext_err || spurious || timed_out);
        ack_hit   = (|samp.size_ack) || samp.vec_ack;
    end

endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
    import bus_term_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bt_samp_t  samp,
    input  logic      err_hit,
    input  logic      ack_hit,
    output bt_state_e state,
    output logic      ok_o,
    output logic      berr_o,
    output logic      hold_o
);

    bt_state_e st_nx;
    logic      ok_nx;
    logic      berr_nx;

    always_comb begin
        st_nx   = state;
        ok_nx   = 1'b0;
        berr_nx = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (samp.halt) begin
                    st_nx = ST_HALT;
                end else if (samp.strobe) begin
                    st_nx = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (!samp.strobe) begin
                    st_nx = ST_IDLE;
                end else if (err_hit) begin
                    st_nx   = ST_DONE;
                    berr_nx = 1'b1;
                end else if (ack_hit) begin
                    st_nx = ST_DONE;
                    ok_nx = 1'b1;
                end
            end
            ST_DONE: begin
                if (!samp.strobe) begin
                    st_nx = samp.halt ? ST_HALT : ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!samp.halt) begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= st_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_o   <= 1'b0;
            berr_o <= 1'b0;
            hold_o <= 1'b0;
        end else begin
            ok_o   <= ok_nx;
            berr_o <= berr_nx;
            hold_o <= (st_nx == ST_HALT);
        end
    end

endmodule

// File: rtl/bus_term_monitor.sv
module bus_term_monitor
    import bus_term_pkg::*;
#(
    parameter int BASE_TMO = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_strobe_i,
    input  logic [1:0]       size_ack_i,
    input  logic             vec_ack_i,
    input  logic             bus_err_i,
    input  logic             halt_req_i,
    input  logic             intack_cycle_i,
    input  logic             arb_clash_i,
    input  logic             stop_bcast_i,
    input  logic             tmo_en_i,
    input  logic [SEL_W-1:0] tmo_sel_i,
    output logic             term_ok_o,
    output logic             int_berr_o,
    output logic             step_hold_o
);

    bt_samp_t         raw;
    bt_samp_t         smp;
    logic [SEL_W-1:0] sel_q;
    bt_state_e        state;
    logic             expire;
    logic             err_hit;
    logic             ack_hit;

    always_comb begin
        raw.strobe   = addr_strobe_i;
        raw.size_ack = size_ack_i;
        raw.vec_ack  = vec_ack_i;
        raw.ext_err  = bus_err_i;
        raw.halt     = halt_req_i;
        raw.intack   = intack_cycle_i;
        raw.clash    = arb_clash_i;
        raw.stop     = stop_bcast_i;
        raw.tmo_en   = tmo_en_i;
    end

    bt_sampler #(.SEL_W(SEL_W)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_d (raw),
        .sel_d  (tmo_sel_i),
        .samp_q (smp),
        .sel_q  (sel_q)
    );

    bt_timeout #(.BASE_TMO(BASE_TMO), .SEL_W(SEL_W)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_ACTIVE),
        .sel    (sel_q),
        .expire (expire)
    );

    bt_err_decode u_dec (
        .samp    (smp),
        .expire  (expire),
        .err_hit (err_hit),
        .ack_hit (ack_hit)
    );

    bt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp    (smp),
        .err_hit (err_hit),
        .ack_hit (ack_hit),
        .state   (state),
        .ok_o    (term_ok_o),
        .berr_o  (int_berr_o),
        .hold_o  (step_hold_o)
    );

endmodule

// File: rtl/bus_term_monitor_chk.sv
module bus_term_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] size_ack_i,
    input logic       vec_ack_i,
    input logic       stop_bcast_i,
    input logic       term_ok_o,
    input logic       int_berr_o,
    input logic       step_hold_o
);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(term_ok_o && int_berr_o));

    p_ok_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        term_ok_o |=> !term_ok_o);

    p_berr_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_berr_o |=> !int_berr_o);

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_hold_o |-> (!term_ok_o && !int_berr_o));

    p_ok_needs_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        term_ok_o |-> (($past(size_ack_i, 2) != 2'b00) || $past(vec_ack_i, 2)));

    p_stop_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_berr_o |-> !$past(stop_bcast_i, 2));

endmodule

bind bus_term_monitor bus_term_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .size_ack_i   (size_ack_i),
    .vec_ack_i    (vec_ack_i),
    .stop_bcast_i (stop_bcast_i),
    .term_ok_o    (term_ok_o),
    .int_berr_o   (int_berr_o),
    .step_hold_o  (step_hold_o)
);

// File: tb/sim_bus_term_monitor.sv
module sim_bus_term_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strobe_i = 1'b0;
    logic [1:0] size_ack_i = 2'b00;
    logic       vec_ack_i = 1'b0;
    logic       bus_err_i = 1'b0;
    logic       halt_req_i = 1'b0;
    logic       intack_cycle_i = 1'b0;
    logic       arb_clash_i = 1'b0;
    logic       stop_bcast_i = 1'b0;
    logic       tmo_en_i = 1'b1;
    logic [1:0] tmo_sel_i = 2'd0;
    logic       term_ok_o;
    logic       int_berr_o;
    logic       step_hold_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        bit    err;
        int    when;
        string req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bus_term_monitor u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr_strobe_i  (addr_strobe_i),
        .size_ack_i     (size_ack_i),
        .vec_ack_i      (vec_ack_i),
        .bus_err_i      (bus_err_i),
        .halt_req_i     (halt_req_i),
        .intack_cycle_i (intack_cycle_i),
        .arb_clash_i    (arb_clash_i),
        .stop_bcast_i   (stop_bcast_i),
        .tmo_en_i       (tmo_en_i),
        .tmo_sel_i      (tmo_sel_i),
        .term_ok_o      (term_ok_o),
        .int_berr_o     (int_berr_o),
        .step_hold_o    (step_hold_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver side: push an expected outcome n edges after the current falling edge
    task automatic expect_evt(input bit err, input int n, input string req);
        exp_t e;
        e.err  = err;
        e.when = cyc + n;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic idle_bus();
        @(negedge clk);
        addr_strobe_i  = 1'b0;
        size_ack_i     = 2'b00;
        vec_ack_i      = 1'b0;
        bus_err_i      = 1'b0;
        intack_cycle_i = 1'b0;
        arb_clash_i    = 1'b0;
        stop_bcast_i   = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic drained(input string req);
        check(sb.size() == 0, req, "outcomes still pending", sb.size(), 0);
    endtask

    // One cycle whose flags are constant from strobe to strobe release
    task automatic run_cyc(input logic [1:0] sa, input logic va, input logic be,
                           input logic ia, input logic cl, input bit exp_err,
                           input int lat, input int hold, input string req);
        @(negedge clk);
        addr_strobe_i  = 1'b1;
        size_ack_i     = sa;
        vec_ack_i      = va;
        bus_err_i      = be;
        intack_cycle_i = ia;
        arb_clash_i    = cl;
        if (lat > 0) expect_evt(exp_err, lat, req);
        repeat (hold) @(posedge clk);
        idle_bus();
        drained(req);
    endtask

    // Monitor side: pop and compare each produced outcome
    always @(posedge clk) begin
        #1;
        if (rst_n && (term_ok_o || int_berr_o)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected termination pulse", cyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(!(term_ok_o && int_berr_o), e.req, "both pulses at once", 1, 0);
                check(int_berr_o == e.err, e.req, "error outcome", int_berr_o, e.err);
                check(cyc == e.when, e.req, "outcome cycle", cyc, e.when);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        check({term_ok_o, int_berr_o, step_hold_o} == 3'b000, "R11", "outputs in reset",
              {term_ok_o, int_berr_o, step_hold_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check({term_ok_o, int_berr_o, step_hold_o} == 3'b000, "R11", "outputs after reset",
              {term_ok_o, int_berr_o, step_hold_o}, 0);

        // R1: each acknowledge form; R10: ack held long gives one pulse only
        run_cyc(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 12, "R1");
        run_cyc(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 6, "R1");
        run_cyc(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 6, "R10");

        // R2: timeout lengths
        tmo_sel_i = 2'd0;
        run_cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10, 14, "R2");
        tmo_sel_i = 2'd1;
        run_cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18, 22, "R2");
        tmo_sel_i = 2'd3;
        run_cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 66, 70, "R2");
        tmo_sel_i = 2'd0;

        // R3: abort clears the count, next cycle timed from its own start
        run_cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 7, "R3");
        run_cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10, 14, "R3");

        // R5 external error; R6 error with ack
        run_cyc(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3, 6, "R5");
        run_cyc(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3, 6, "R6");

        // R6: ack on the clock the timeout expires
        @(negedge clk);
        addr_strobe_i = 1'b1;
        expect_evt(1'b1, 10, "R6");
        repeat (8) @(posedge clk);
        @(negedge clk);
        vec_ack_i = 1'b1;
        repeat (4) @(posedge clk);
        idle_bus();
        drained("R6");

        // R4: spurious vs arbitrated interrupt acknowledge
        run_cyc(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3, 6, "R4");
        run_cyc(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3, 6, "R4");

        // R7: broadcast cycle masks external error and timeout
        @(negedge clk);
        addr_strobe_i = 1'b1;
        stop_bcast_i  = 1'b1;
        bus_err_i     = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        size_ack_i = 2'b01;
        expect_evt(1'b0, 2, "R7");
        repeat (4) @(posedge clk);
        idle_bus();
        drained("R7");

        // R8: timeout disabled, spurious still active
        tmo_en_i = 1'b0;
        @(negedge clk);
        addr_strobe_i = 1'b1;
        repeat (80) @(posedge clk);
        @(negedge clk);
        vec_ack_i = 1'b1;
        expect_evt(1'b0, 2, "R8");
        repeat (4) @(posedge clk);
        idle_bus();
        drained("R8");
        run_cyc(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3, 6, "R8");
        tmo_en_i = 1'b1;

        // R9: halt holds the bus until release
        @(negedge clk);
        halt_req_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(step_hold_o == 1'b1, "R9", "hold while halted", step_hold_o, 1);
        @(negedge clk);
        addr_strobe_i = 1'b1;
        size_ack_i    = 2'b10;
        repeat (10) @(posedge clk);
        #1;
        check(step_hold_o == 1'b1, "R9", "hold with cycle waiting", step_hold_o, 1);
        drained("R9");
        @(negedge clk);
        halt_req_i = 1'b0;
        expect_evt(1'b0, 4, "R9");
        repeat (8) @(posedge clk);
        #1;
        check(step_hold_o == 1'b0, "R9", "hold released", step_hold_o, 0);
        idle_bus();
        drained("R9");

        repeat (5) @(posedge clk);
        finish_up();
    end

endmodule